// File: doc/BRIEF.md
# Line-Merging Miss Tracker Between Two Cache Levels

This block sits on the miss path from a first-level cache to the second-level cache. Every first-level miss presents a byte address and a small requester id. The block keeps a handful of tracking slots, each holding one line address. A miss to a line that no slot holds claims a free slot, and that slot then sends exactly one request to the second level. A miss to a line that a slot already holds, whether its request is still waiting or already sent, is folded into that slot. No further request leaves for it; only the requester id is remembered.

When the second level returns a fill, the fill names its line. The matching slot reports the set of requester ids that were waiting on it and is released. Data movement and the replay of folded misses are handled elsewhere; this block only says which ids are complete. Three running counters expose how many misses arrived, how many requests actually went out, and how many misses were folded, so the gap between first-level misses and second-level traffic can be measured.

Top module: `miss_merge_buf`

## Requirements
- R1: After reset, `miss_ready` is 1, `l2_req_valid` and `done_valid` are 0, and all three counters read 0.
- R2: The line address is the byte address with its six low bits removed (64-byte lines). Two misses belong to the same line exactly when their addresses agree above bit 5, and `l2_req_line` carries that line address.
- R3: An accepted miss whose line is held by no slot claims a free slot. `l2_req_valid` rises in the cycle after acceptance, and exactly one second-level request is issued for that line.
- R4: An accepted miss whose line is held by a busy slot (request waiting or already sent) issues no new request, and its requester id is added to that slot's id set.
- R5: Sixty-four misses to consecutive byte addresses starting at a line-aligned address raise the miss count by 64, the squash count by 63 and the request count by 1.
- R6: There are four slots. While all four are busy, `miss_ready` is 0 for a miss to a new line and stays 1 for a miss to a line a slot holds.
- R7: While `l2_req_valid` is 1 and `l2_req_ready` is 0, the request stays valid and `l2_req_line` holds its value in the next cycle.
- R8: A fill whose line matches a slot whose request was sent drives `done_valid` to 1 in that same cycle, with `done_mask` bit n set for each requester id n folded into the slot. The slot is free from the next cycle on, so a later miss to that line issues a new request.
- R9: A miss accepted in the same cycle as the fill for its line is reported in that cycle's `done_mask`. It is counted as squashed, and it claims no slot and sends no request.
- R10: The miss counter increments for each accepted miss, the request counter for each `l2_req_valid`/`l2_req_ready` handshake, and the squash counter for each folded miss. Each counter changes in the cycle after its event.
- R11: A fill whose line matches no slot with a sent request leaves `done_valid` at 0 and changes no counter and no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | A first-level miss is presented |
| miss_ready | output | 1 | The presented miss is accepted this cycle |
| miss_addr | input | ADDR_W | Byte address of the miss |
| miss_id | input | clog2(REQ_IDS) | Requester id of the miss |
| l2_req_valid | output | 1 | A line request to the second level is offered |
| l2_req_ready | input | 1 | The second level takes the request |
| l2_req_line | output | ADDR_W-6 | Line address of the offered request |
| fill_valid | input | 1 | A fill response is present |
| fill_line | input | ADDR_W-6 | Line address of the fill |
| done_valid | output | 1 | A slot completes this cycle |
| done_mask | output | REQ_IDS | Requester ids released by the completing slot |
| cnt_l1_miss | output | CNT_W | Accepted misses |
| cnt_l2_req | output | CNT_W | Requests sent to the second level |
| cnt_squash | output | CNT_W | Misses folded into an existing slot |

## Verification
The assertions assume that the second level returns at most one fill per cycle. They also assume it fills only lines it was actually asked for and has not yet answered, so at most one slot can match a fill. A fill to a slot whose request is still waiting is never expected. The stimulus respects this: it issues each fill only after the request handshake for that line has completed. It never fills a line twice, and it fills one unrelated line only to exercise R11. Requester ids may repeat within one line, since folding is a set union, and the stimulus never lets the counters wrap.

// File: rtl/mmb_pkg.sv
// Package: shared types for the line-merging miss tracker.
// Assumes nothing beyond being compiled before the modules that import it.
package mmb_pkg;

    // Life cycle of one tracking slot.
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,   // holds nothing
        SLOT_WAIT = 2'd1,   // line claimed, request not yet taken by level two
        SLOT_SENT = 2'd2    // request taken, waiting for the fill
    } slot_state_e;

    // Positions of the event counters in the counter bank.
    localparam int CNT_IDX_MISS   = 0;
    localparam int CNT_IDX_L2     = 1;
    localparam int CNT_IDX_SQUASH = 2;
    localparam int CNT_NUM        = 3;

endpackage

// File: rtl/mmb_slot.sv
// Module: one tracking slot. It holds a line address, the set of requester
// ids waiting on it, and its life-cycle state.
// Assumes: claim only when free; sent only while waiting; fill_hit is
// produced here and only for a slot whose request was sent.
module mmb_slot
    import mmb_pkg::*;
#(
    parameter int LINE_W  = 26,
    parameter int REQ_IDS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               claim,
    input  logic               fold,
    input  logic               sent,
    input  logic [LINE_W-1:0]  new_line,
    input  logic [REQ_IDS-1:0] new_id_bit,
    input  logic               fill_valid,
    input  logic [LINE_W-1:0]  fill_line,
    input  logic [LINE_W-1:0]  probe_line,
    output logic               busy,
    output logic               waiting,
    output logic               probe_hit,
    output logic               fill_hit,
    output logic [LINE_W-1:0]  line,
    output logic [REQ_IDS-1:0] ids
);

    slot_state_e state_q;

    // Purpose: decode the slot state and compare the held line.
    always_comb begin
        busy      = (state_q != SLOT_FREE);
        waiting   = (state_q == SLOT_WAIT);
        probe_hit = busy && (line == probe_line);
        fill_hit  = fill_valid && (state_q == SLOT_SENT) && (line == fill_line);
    end

    // Purpose: advance the slot through free, waiting and sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
            line    <= '0;
            ids     <= '0;
        end else if (fill_hit) begin
            state_q <= SLOT_FREE;
            ids     <= '0;
        end else if (claim) begin
            state_q <= SLOT_WAIT;
            line    <= new_line;
            ids     <= new_id_bit;
        end else begin
            if (fold) begin
                ids <= ids | new_id_bit;
            end
            if (sent && state_q == SLOT_WAIT) begin
                state_q <= SLOT_SENT;
            end
        end
    end

endmodule

// File: rtl/mmb_first.sv
// Module: lowest-index picker. It grants the lowest set bit of a request vector.
// Assumes nothing about the request pattern; an empty vector grants nothing.
module mmb_first #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);

    // Purpose: walk from the top so the lowest set bit wins.
    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
            end
        end
        any = |req;
    end

endmodule

// File: rtl/mmb_counters.sv
// Module: bank of free-running event counters, one increment strobe each.
// Assumes the width is wide enough for the run; counters wrap silently.
module mmb_counters #(
    parameter int NUM   = 3,
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM-1:0]            inc,
    output logic [NUM-1:0][CNT_W-1:0] value
);

    for (genvar g = 0; g < NUM; g++) begin : g_cnt
        // Purpose: count one event kind.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                value[g] <= '0;
            end else if (inc[g]) begin
                value[g] <= value[g] + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/miss_merge_buf.sv
// Module: line-merging miss tracker between a first- and second-level cache.
// A miss to an untracked line claims a slot and sends one request; misses to
// a tracked line are folded in. A fill releases the slot and reports its ids.
// Assumes: at most one fill per cycle, only for lines whose request was sent
// and not yet answered.
module miss_merge_buf
    import mmb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int ENTRIES    = 4,
    parameter int REQ_IDS    = 8,
    parameter int CNT_W      = 16,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - OFF_W,
    localparam int ID_W      = $clog2(REQ_IDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               miss_valid,
    output logic               miss_ready,
    input  logic [ADDR_W-1:0]  miss_addr,
    input  logic [ID_W-1:0]    miss_id,
    output logic               l2_req_valid,
    input  logic               l2_req_ready,
    output logic [LINE_W-1:0]  l2_req_line,
    input  logic               fill_valid,
    input  logic [LINE_W-1:0]  fill_line,
    output logic               done_valid,
    output logic [REQ_IDS-1:0] done_mask,
    output logic [CNT_W-1:0]   cnt_l1_miss,
    output logic [CNT_W-1:0]   cnt_l2_req,
    output logic [CNT_W-1:0]   cnt_squash
);

    logic [LINE_W-1:0]               miss_line;
    logic [REQ_IDS-1:0]              id_bit;
    logic [ENTRIES-1:0]              busy, waiting, probe_hit, fill_hit;
    logic [ENTRIES-1:0][LINE_W-1:0]  slot_line;
    logic [ENTRIES-1:0][REQ_IDS-1:0] slot_ids;
    logic [ENTRIES-1:0]              free_gnt, send_gnt, sel;
    logic [ENTRIES-1:0]              claim_vec, fold_vec, sent_vec;
    logic                            free_any, send_any, hit_any, accept;
    logic                            hold_q;
    logic [ENTRIES-1:0]              hold_sel_q;
    logic [CNT_NUM-1:0]              cnt_inc;
    logic [CNT_NUM-1:0][CNT_W-1:0]   cnt_val;

    // Purpose: split the miss into its line address and a one-hot id.
    always_comb begin
        miss_line = miss_addr[ADDR_W-1:OFF_W];
        id_bit    = '0;
        id_bit[miss_id] = 1'b1;
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        mmb_slot #(
            .LINE_W  (LINE_W),
            .REQ_IDS (REQ_IDS)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .claim      (claim_vec[e]),
            .fold       (fold_vec[e]),
            .sent       (sent_vec[e]),
            .new_line   (miss_line),
            .new_id_bit (id_bit),
            .fill_valid (fill_valid),
            .fill_line  (fill_line),
            .probe_line (miss_line),
            .busy       (busy[e]),
            .waiting    (waiting[e]),
            .probe_hit  (probe_hit[e]),
            .fill_hit   (fill_hit[e]),
            .line       (slot_line[e]),
            .ids        (slot_ids[e])
        );
    end

    mmb_first #(.N(ENTRIES)) u_free_pick (
        .req (~busy),
        .gnt (free_gnt),
        .any (free_any)
    );

    mmb_first #(.N(ENTRIES)) u_send_pick (
        .req (waiting),
        .gnt (send_gnt),
        .any (send_any)
    );

    // Purpose: accept, claim or fold the presented miss.
    always_comb begin
        hit_any    = |probe_hit;
        miss_ready = hit_any || free_any;
        accept     = miss_valid && miss_ready;
        claim_vec  = (accept && !hit_any) ? free_gnt : '0;
        fold_vec   = accept ? probe_hit : '0;
    end

    // Purpose: choose the offered request, keeping it while it is refused.
    always_comb begin
        sel          = hold_q ? hold_sel_q : (send_any ? send_gnt : '0);
        l2_req_valid = |sel;
        l2_req_line  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (sel[i]) begin
                l2_req_line = slot_line[i];
            end
        end
        sent_vec = l2_req_ready ? sel : '0;
    end

    // Purpose: remember a refused request so it stays on the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= 1'b0;
            hold_sel_q <= '0;
        end else begin
            hold_q     <= l2_req_valid && !l2_req_ready;
            hold_sel_q <= sel;
        end
    end

    // Purpose: report the completing slot's ids plus any miss folded this cycle.
    always_comb begin
        done_valid = |fill_hit;
        done_mask  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (fill_hit[i]) begin
                done_mask = done_mask | slot_ids[i] | (fold_vec[i] ? id_bit : '0);
            end
        end
    end

    // Purpose: raise the counter strobes.
    always_comb begin
        cnt_inc                 = '0;
        cnt_inc[CNT_IDX_MISS]   = accept;
        cnt_inc[CNT_IDX_L2]     = l2_req_valid && l2_req_ready;
        cnt_inc[CNT_IDX_SQUASH] = accept && hit_any;
    end

    mmb_counters #(.NUM(CNT_NUM), .CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cnt_inc),
        .value (cnt_val)
    );

    assign cnt_l1_miss = cnt_val[CNT_IDX_MISS];
    assign cnt_l2_req  = cnt_val[CNT_IDX_L2];
    assign cnt_squash  = cnt_val[CNT_IDX_SQUASH];

endmodule

// File: rtl/mmb_checker.sv
// Module: property checker for the line-merging miss tracker, bound to the top.
// Assumes the input rules stated in the top module header.
module mmb_checker #(
    parameter int ENTRIES = 4,
    parameter int REQ_IDS = 8,
    parameter int LINE_W  = 26,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               miss_valid,
    input logic               miss_ready,
    input logic               l2_req_valid,
    input logic               l2_req_ready,
    input logic [LINE_W-1:0]  l2_req_line,
    input logic               done_valid,
    input logic [REQ_IDS-1:0] done_mask,
    input logic [CNT_W-1:0]   cnt_l1_miss,
    input logic [CNT_W-1:0]   cnt_l2_req,
    input logic [CNT_W-1:0]   cnt_squash,
    input logic [ENTRIES-1:0] busy,
    input logic [ENTRIES-1:0] probe_hit,
    input logic [ENTRIES-1:0] fill_hit
);

    assert_stall_only_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_ready |-> (&busy));

    assert_one_slot_per_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(probe_hit));

    assert_single_fill_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_hit));

    assert_done_has_ids_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_mask != '0));

    assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_req_valid && !l2_req_ready) |=> (l2_req_valid && $stable(l2_req_line)));

    assert_miss_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> (cnt_l1_miss == $past(cnt_l1_miss) + CNT_W'(1)));

    assert_traffic_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt_l2_req} + {1'b0, cnt_squash}) <= {1'b0, cnt_l1_miss});

endmodule

bind miss_merge_buf mmb_checker #(
    .ENTRIES (ENTRIES),
    .REQ_IDS (REQ_IDS),
    .LINE_W  (LINE_W),
    .CNT_W   (CNT_W)
) u_mmb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_valid   (miss_valid),
    .miss_ready   (miss_ready),
    .l2_req_valid (l2_req_valid),
    .l2_req_ready (l2_req_ready),
    .l2_req_line  (l2_req_line),
    .done_valid   (done_valid),
    .done_mask    (done_mask),
    .cnt_l1_miss  (cnt_l1_miss),
    .cnt_l2_req   (cnt_l2_req),
    .cnt_squash   (cnt_squash),
    .busy         (busy),
    .probe_hit    (probe_hit),
    .fill_hit     (fill_hit)
);

// File: tb/miss_merge_buf_bench.sv
// Bench: directed sequences plus sweeps over line offsets and id-set sizes.
// Inputs change one time unit after a rising edge; outputs are sampled a
// time unit later, well away from the next edge.
module miss_merge_buf_bench;

    localparam int ADDR_W = 32;
    localparam int LINE_W = 26;
    localparam int IDS    = 8;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              miss_valid = 1'b0;
    logic              miss_ready;
    logic [ADDR_W-1:0] miss_addr = '0;
    logic [2:0]        miss_id = '0;
    logic              l2_req_valid;
    logic              l2_req_ready = 1'b1;
    logic [LINE_W-1:0] l2_req_line;
    logic              fill_valid = 1'b0;
    logic [LINE_W-1:0] fill_line = '0;
    logic              done_valid;
    logic [IDS-1:0]    done_mask;
    logic [CNT_W-1:0]  cnt_l1_miss, cnt_l2_req, cnt_squash;

    int checks = 0;
    int bad = 0;
    int exp_miss = 0;
    int exp_l2 = 0;
    int exp_sq = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    miss_merge_buf u_miss_merge_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .miss_valid   (miss_valid),
        .miss_ready   (miss_ready),
        .miss_addr    (miss_addr),
        .miss_id      (miss_id),
        .l2_req_valid (l2_req_valid),
        .l2_req_ready (l2_req_ready),
        .l2_req_line  (l2_req_line),
        .fill_valid   (fill_valid),
        .fill_line    (fill_line),
        .done_valid   (done_valid),
        .done_mask    (done_mask),
        .cnt_l1_miss  (cnt_l1_miss),
        .cnt_l2_req   (cnt_l2_req),
        .cnt_squash   (cnt_squash)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Present one miss for one cycle; report whether it was taken.
    task automatic miss_try(input logic [31:0] addr, input int id,
                            input bit is_fold, output bit acc);
        miss_valid = 1'b1;
        miss_addr  = addr;
        miss_id    = 3'(id);
        #1;
        acc = miss_ready;
        tick();
        miss_valid = 1'b0;
        if (acc) begin
            exp_miss++;
            if (is_fold) exp_sq++;
            else exp_l2++;
        end
    endtask

    // Present one fill for one cycle and check the completion outputs.
    task automatic fill_chk(input string req, input logic [LINE_W-1:0] ln,
                            input bit exp_done, input logic [IDS-1:0] exp_mask);
        fill_valid = 1'b1;
        fill_line  = ln;
        #1;
        chk(req, "done_valid", 32'(done_valid), 32'(exp_done));
        if (exp_done) chk(req, "done_mask", 32'(done_mask), 32'(exp_mask));
        tick();
        fill_valid = 1'b0;
    endtask

    task automatic chk_counters(input string req);
        chk(req, "cnt_l1_miss", 32'(cnt_l1_miss), 32'(exp_miss));
        chk(req, "cnt_l2_req",  32'(cnt_l2_req),  32'(exp_l2));
        chk(req, "cnt_squash",  32'(cnt_squash),  32'(exp_sq));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: got=expired expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        bit acc;
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "miss_ready", 32'(miss_ready), 32'd1);
        chk("R1", "l2_req_valid", 32'(l2_req_valid), 32'd0);
        chk("R1", "done_valid", 32'(done_valid), 32'd0);
        chk_counters("R1");
        tick();

        // R3: a new line raises the request one cycle after acceptance
        l2_req_ready = 1'b0;
        miss_try(32'h1000, 0, 1'b0, acc);
        chk("R3", "accepted", 32'(acc), 32'd1);
        chk("R3", "l2_req_valid", 32'(l2_req_valid), 32'd1);
        chk("R3", "l2_req_line", 32'(l2_req_line), 32'h40);
        // R2: last byte of the line folds; first byte of the next line does not
        miss_try(32'h103F, 1, 1'b1, acc);
        chk("R2", "fold accepted", 32'(acc), 32'd1);
        miss_try(32'h1040, 2, 1'b0, acc);
        // R7: refused request holds its line while another slot waits
        chk("R7", "l2_req_valid", 32'(l2_req_valid), 32'd1);
        chk("R7", "l2_req_line", 32'(l2_req_line), 32'h40);
        tick();
        chk("R7", "l2_req_line later", 32'(l2_req_line), 32'h40);
        chk("R4", "cnt_squash", 32'(cnt_squash), 32'd1);
        l2_req_ready = 1'b1;
        tick();
        chk("R2", "second line offered", 32'(l2_req_line), 32'h41);
        tick();
        chk("R3", "no more requests", 32'(l2_req_valid), 32'd0);
        chk_counters("R10");

        // R11: unrelated fill is ignored
        fill_chk("R11", 26'h99, 1'b0, '0);
        chk_counters("R11");
        // R8 / R4: fills report the folded id sets
        fill_chk("R8", 26'h40, 1'b1, 8'b0000_0011);
        fill_chk("R8", 26'h41, 1'b1, 8'b0000_0100);
        // R8: freed slot lets the same line request again
        miss_try(32'h1000, 3, 1'b0, acc);
        chk("R8", "re-request valid", 32'(l2_req_valid), 32'd1);
        chk("R8", "re-request line", 32'(l2_req_line), 32'h40);
        tick();
        fill_chk("R8", 26'h40, 1'b1, 8'b0000_1000);

        // R9: miss arriving with its own fill
        miss_try(32'h3000, 2, 1'b0, acc);
        tick();
        fill_valid = 1'b1;
        fill_line  = 26'hC0;
        miss_valid = 1'b1;
        miss_addr  = 32'h3010;
        miss_id    = 3'd5;
        #1;
        chk("R9", "miss_ready", 32'(miss_ready), 32'd1);
        chk("R9", "done_valid", 32'(done_valid), 32'd1);
        chk("R9", "done_mask", 32'(done_mask), 32'h24);
        tick();
        fill_valid = 1'b0;
        miss_valid = 1'b0;
        exp_miss++;
        exp_sq++;
        #1;
        chk("R9", "no new request", 32'(l2_req_valid), 32'd0);
        chk_counters("R9");

        // R5: sweep of 64 consecutive bytes in one line
        for (int k = 0; k < 64; k++) begin
            miss_try(32'h2000 + 32'(k), k % 8, k != 0, acc);
        end
        tick();
        chk_counters("R5");
        fill_chk("R5", 26'h80, 1'b1, 8'hFF);

        // R4 / R8: sweep of id-set sizes on fresh lines
        for (int n = 1; n <= 8; n++) begin
            for (int i = 0; i < n; i++) begin
                miss_try(32'h5000 + 32'(n * 64) + 32'(i), i, i != 0, acc);
            end
            tick();
            fill_chk("R4", 26'(32'h140 + 32'(n)), 1'b1, 8'((1 << n) - 1));
        end

        // R6: all slots busy stalls new lines, not tracked ones
        for (int s = 0; s < 4; s++) begin
            miss_try(32'h8000 + 32'(s * 64), 0, 1'b0, acc);
        end
        miss_try(32'h9000, 1, 1'b0, acc);
        chk("R6", "new line stalled", 32'(acc), 32'd0);
        miss_try(32'h8040, 1, 1'b1, acc);
        chk("R6", "tracked line accepted", 32'(acc), 32'd1);
        tick();
        tick();
        fill_chk("R6", 26'h200, 1'b1, 8'b01);
        miss_try(32'h9000, 1, 1'b0, acc);
        chk("R6", "accepted after free", 32'(acc), 32'd1);
        fill_chk("R6", 26'h201, 1'b1, 8'b11);
        fill_chk("R6", 26'h202, 1'b1, 8'b01);
        fill_chk("R6", 26'h203, 1'b1, 8'b01);
        fill_chk("R6", 26'h240, 1'b1, 8'b10);
        tick();
        chk_counters("R10");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule